// File: doc/BRIEF.md
# Operand-Gathering Reservation Station Pool

This block holds a few waiting operations in front of one class of execution unit, for example floating-point add and subtract. An issue stage hands it an opcode and two source operands. Each operand comes either as a value that is already known, or as the tag of the operation that will produce it. Operands that still wait on a producer are filled by watching a shared result bus. Every entry compares its pending tags with the tag on that bus and takes the value when they match. No register file is read.

When both operands of an entry are present, the block offers that entry to the execution unit, one entry per cycle. The entry stays allocated while the unit works on it. It is released when a result carrying the entry's own tag appears on the result bus. The tag of an entry is its index plus a base value. Tag zero is reserved to mean "no producer". The block reports whether it is full, and which tag the next issued operation will receive. The issue stage uses that tag to rename the destination register.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every entry is free: `full` is 0, `disp_valid` is 0 and `iss_tag` equals TAG_BASE.
- R2: An accepted issue is written into the lowest-numbered free entry. `iss_tag` shows that entry's tag, which is TAG_BASE plus the entry index (1, 2, 3 with defaults).
- R3: `full` is 1 exactly when every entry is busy. An issue presented while `full` is 1 is ignored and changes no entry.
- R4: A source given with tag 0 is stored as a present value taken from the matching value input.
- R5: A busy entry whose source tag is nonzero captures `bc_data` when `bc_valid` is 1 and `bc_tag` equals that tag. The source then counts as present from the next cycle on.
- R6: If a source is issued with a nonzero tag that matches the result bus in the same cycle, the bus value is stored at issue and the source is present from the next cycle on.
- R7: `disp_valid` is 1 only for an entry whose two sources are both present. `disp_tag`, `disp_op`, `disp_a` and `disp_b` then carry that entry's tag, opcode and operand values.
- R8: When several entries are ready and not yet sent, the lowest-numbered one is offered. An offered entry counts as sent at the next clock edge and is never offered again.
- R9: A busy entry becomes free at the clock edge where `bc_valid` is 1 and `bc_tag` equals its own tag. This is the only way an entry is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_qa | input | TAG_W | Producer tag of source A, 0 if the value is known |
| iss_va | input | DATA_W | Value of source A when its tag is 0 |
| iss_qb | input | TAG_W | Producer tag of source B, 0 if the value is known |
| iss_vb | input | DATA_W | Value of source B when its tag is 0 |
| full | output | 1 | All entries busy, issue stalls |
| iss_tag | output | TAG_W | Tag the next accepted issue will receive |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the producer of the bus result |
| bc_data | input | DATA_W | Result value on the bus |
| disp_valid | output | 1 | An entry is offered to the execution unit |
| disp_tag | output | TAG_W | Tag of the offered entry |
| disp_op | output | OP_W | Opcode of the offered entry |
| disp_a | output | DATA_W | Source A value of the offered entry |
| disp_b | output | DATA_W | Source B value of the offered entry |

## Verification
The bench uses the default parameters: three entries, 4-bit tags starting at 1, 64-bit data and 4-bit opcodes. With only three entries, a few issues are enough to fill the pool. The bench can then show a stalled issue being dropped, freed entries being reused lowest first, and chains where one entry waits on another entry's tag. External producer tags above 3 reach entries only through the snoop path. The same-cycle issue-and-broadcast case is exercised while the pool is filling.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N        = 3,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qa,
  input  logic [DATA_W-1:0] iss_va,
  input  logic [TAG_W-1:0]  iss_qb,
  input  logic [DATA_W-1:0] iss_vb,
  output logic              full,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [TAG_W-1:0] NO_TAG = '0;

  logic              busy_q [N];
  logic              sent_q [N];
  logic [OP_W-1:0]   op_q   [N];
  logic [TAG_W-1:0]  qa_q   [N];
  logic [TAG_W-1:0]  qb_q   [N];
  logic [DATA_W-1:0] va_q   [N];
  logic [DATA_W-1:0] vb_q   [N];

  logic [IDX_W-1:0] alloc_idx, disp_idx;
  logic             alloc_any;
  logic             do_iss;
  logic             byp_a, byp_b;

  always_comb begin
    alloc_idx = '0;
    alloc_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        alloc_idx = IDX_W'(i);
        alloc_any = 1'b1;
      end
    end
  end

  always_comb begin
    disp_idx   = '0;
    disp_valid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (busy_q[i] && !sent_q[i] && qa_q[i] == NO_TAG && qb_q[i] == NO_TAG) begin
        disp_idx   = IDX_W'(i);
        disp_valid = 1'b1;
      end
    end
  end

  assign full     = ~alloc_any;
  assign iss_tag  = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
  assign do_iss   = iss_valid & alloc_any;
  assign byp_a    = bc_valid && iss_qa != NO_TAG && bc_tag == iss_qa;
  assign byp_b    = bc_valid && iss_qb != NO_TAG && bc_tag == iss_qb;

  assign disp_tag = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);
  assign disp_op  = op_q[disp_idx];
  assign disp_a   = va_q[disp_idx];
  assign disp_b   = vb_q[disp_idx];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(TAG_BASE + g);
    logic hit_a, hit_b, done, take, fire;

    assign hit_a = bc_valid && qa_q[g] != NO_TAG && bc_tag == qa_q[g];
    assign hit_b = bc_valid && qb_q[g] != NO_TAG && bc_tag == qb_q[g];
    assign done  = busy_q[g] && bc_valid && bc_tag == MY_TAG;
    assign take  = do_iss && alloc_idx == IDX_W'(g);
    assign fire  = disp_valid && disp_idx == IDX_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        sent_q[g] <= 1'b0;
        op_q[g]   <= '0;
        qa_q[g]   <= NO_TAG;
        qb_q[g]   <= NO_TAG;
        va_q[g]   <= '0;
        vb_q[g]   <= '0;
      end else if (take) begin
        busy_q[g] <= 1'b1;
        sent_q[g] <= 1'b0;
        op_q[g]   <= iss_op;
        qa_q[g]   <= byp_a ? NO_TAG : iss_qa;
        va_q[g]   <= byp_a ? bc_data : iss_va;
        qb_q[g]   <= byp_b ? NO_TAG : iss_qb;
        vb_q[g]   <= byp_b ? bc_data : iss_vb;
      end else begin
        if (done) begin
          busy_q[g] <= 1'b0;
          sent_q[g] <= 1'b0;
        end else if (fire) begin
          sent_q[g] <= 1'b1;
        end
        if (hit_a) begin
          va_q[g] <= bc_data;
          qa_q[g] <= NO_TAG;
        end
        if (hit_b) begin
          vb_q[g] <= bc_data;
          qb_q[g] <= NO_TAG;
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 3,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             full,
  input logic [TAG_W-1:0] iss_tag,
  input logic             bc_valid,
  input logic             disp_valid,
  input logic [TAG_W-1:0] disp_tag
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (!full && !disp_valid));

  assert_alloc_not_offered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !full && disp_valid) |-> (iss_tag != disp_tag));

  assert_full_from_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(iss_valid));

  assert_offer_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_tag) >= TAG_BASE && int'(disp_tag) < TAG_BASE + N));

  assert_no_reoffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));

  assert_free_by_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(bc_valid));
endmodule

bind rs_pool rs_pool_chk #(.N(N), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .full(full), .iss_tag(iss_tag),
  .bc_valid(bc_valid), .disp_valid(disp_valid), .disp_tag(disp_tag)
);

// File: tb/rs_pool_tb.sv
`timescale 1ns/1ps
module rs_pool_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_op = '0, iss_qa = '0, iss_qb = '0;
  logic [63:0] iss_va = '0, iss_vb = '0;
  logic        full;
  logic [3:0]  iss_tag;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [63:0] bc_data = '0;
  logic        disp_valid;
  logic [3:0]  disp_tag, disp_op;
  logic [63:0] disp_a, disp_b;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rs_pool u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_qa(iss_qa), .iss_va(iss_va), .iss_qb(iss_qb), .iss_vb(iss_vb),
    .full(full), .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b)
  );

  typedef struct packed {
    logic        iv;
    logic [3:0]  op;
    logic [3:0]  qa;
    logic [15:0] va;
    logic [3:0]  qb;
    logic [15:0] vb;
    logic        bv;
    logic [3:0]  bt;
    logic [15:0] bd;
    logic        efull;
    logic        edv;
    logic [3:0]  etag;
    logic [3:0]  eop;
    logic [15:0] ea;
    logic [15:0] eb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1, 4'd0, 16'd10, 4'd0, 16'd20,  1'b0, 4'd0, 16'd0,   1'b0, 1'b1, 4'd1, 4'd1, 16'd10,  16'd20},
    '{1'b1, 4'd2, 4'd8, 16'd0,  4'd0, 16'd5,   1'b0, 4'd0, 16'd0,   1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0},
    '{1'b1, 4'd3, 4'd9, 16'd0,  4'd8, 16'd0,   1'b1, 4'd8, 16'd100, 1'b1, 1'b1, 4'd2, 4'd2, 16'd100, 16'd5},
    '{1'b0, 4'd0, 4'd0, 16'd0,  4'd0, 16'd0,   1'b1, 4'd1, 16'd30,  1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0},
    '{1'b1, 4'd4, 4'd3, 16'd0,  4'd2, 16'd0,   1'b1, 4'd9, 16'd7,   1'b1, 1'b1, 4'd3, 4'd3, 16'd7,   16'd100},
    '{1'b1, 4'd5, 4'd0, 16'd1,  4'd0, 16'd1,   1'b1, 4'd2, 16'd50,  1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0},
    '{1'b0, 4'd0, 4'd0, 16'd0,  4'd0, 16'd0,   1'b1, 4'd3, 16'd60,  1'b0, 1'b1, 4'd1, 4'd4, 16'd60,  16'd50},
    '{1'b0, 4'd0, 4'd0, 16'd0,  4'd0, 16'd0,   1'b0, 4'd0, 16'd0,   1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0},
    '{1'b0, 4'd0, 4'd0, 16'd0,  4'd0, 16'd0,   1'b1, 4'd1, 16'd99,  1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0},
    '{1'b1, 4'd6, 4'd0, 16'd1,  4'd0, 16'd2,   1'b0, 4'd0, 16'd0,   1'b0, 1'b1, 4'd1, 4'd6, 16'd1,   16'd2},
    '{1'b1, 4'd7, 4'd0, 16'd3,  4'd0, 16'd4,   1'b0, 4'd0, 16'd0,   1'b0, 1'b1, 4'd2, 4'd7, 16'd3,   16'd4},
    '{1'b1, 4'd8, 4'd0, 16'd5,  4'd0, 16'd6,   1'b0, 4'd0, 16'd0,   1'b1, 1'b1, 4'd3, 4'd8, 16'd5,   16'd6},
    '{1'b0, 4'd0, 4'd0, 16'd0,  4'd0, 16'd0,   1'b1, 4'd1, 16'd9,   1'b0, 1'b0, 4'd0, 4'd0, 16'd0,   16'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    iss_valid = v.iv; iss_op = v.op;
    iss_qa = v.qa; iss_va = {48'd0, v.va};
    iss_qb = v.qb; iss_vb = {48'd0, v.vb};
    bc_valid = v.bv; bc_tag = v.bt; bc_data = {48'd0, v.bd};
    @(posedge clk);
    #1;
    iss_valid = 1'b0; bc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 full", full, 0);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 iss_tag", iss_tag, 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk($sformatf("R3 full step %0d", i), full, VEC[i].efull);
      chk($sformatf("R7 R8 disp_valid step %0d", i), disp_valid, VEC[i].edv);
      if (VEC[i].edv) begin
        chk($sformatf("R8 disp_tag step %0d", i), disp_tag, VEC[i].etag);
        chk($sformatf("R7 disp_op step %0d", i), disp_op, VEC[i].eop);
        chk($sformatf("R4 R5 R6 disp_a step %0d", i), disp_a, {48'd0, VEC[i].ea});
        chk($sformatf("R4 R5 R6 disp_b step %0d", i), disp_b, {48'd0, VEC[i].eb});
      end
    end

    chk("R2 iss_tag lowest free", iss_tag, 1);
    drive('{1'b1, 4'd9, 4'd0, 16'd11, 4'd0, 16'd12, 1'b0, 4'd0, 16'd0, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 16'd0});
    chk("R2 reused entry offered", disp_tag, 1);
    chk("R2 reused entry data", disp_a, 64'd11);
    chk("R3 full after refill", full, 1);

    drive('{1'b0, 4'd0, 4'd0, 16'd0, 4'd0, 16'd0, 1'b1, 4'd3, 16'd0, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 16'd0});
    chk("R9 freed entry tag", iss_tag, 3);
    chk("R9 not full", full, 0);

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 full after reset", full, 0);
    chk("R1 disp_valid after reset", disp_valid, 0);
    chk("R1 iss_tag after reset", iss_tag, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule